// File: doc/BRIEF.md
# Multi-Latency Issue Interlock with Forwarding Select

This block decides, every cycle, whether the instruction sitting in the decode stage of an in-order pipeline may enter execution. The pipeline has four execution paths of different depth: a one-stage integer unit, a two-stage pipelined FP adder, a three-stage pipelined FP multiplier and a four-cycle FP divider that accepts one operation at a time. All four paths feed a shared memory stage and one writeback port. The interlock sees the decoded unit class, destination and two source register numbers. It raises `stall` on a read-after-write, write-after-write, divider-busy or writeback-slot hazard. Otherwise it raises `issue` and tells the operand muxes where each source value will come from.

Internally a 32-entry pending table records, for each register, the unit producing it and how many cycles remain until its writeback. A shift-register reservation vector holds the future writeback cycles. Per-unit shift registers track which execution stage holds a live operation. The divider is controlled by a two-state machine. In `DV_IDLE` a divide moves it to `DV_RUN` (transition "launch"). In `DV_RUN` it counts the occupancy down (transition "count"). In its final cycle it either accepts a following divide (transition "chain", staying in `DV_RUN`) or returns to `DV_IDLE` (transition "drain"). While stalled, the decode stage holds its contents and every execution path receives a bubble.

An instruction that issues in cycle t with unit depth L occupies its execution stages in cycles t+1 to t+L. It is in the memory stage in t+L+1 and in writeback in t+L+2.

Top module: `fpil_interlock`

## Requirements
- R1: A synchronous reset clears the pending table, the writeback reservations, the divider state and all stage occupancy. In the first cycle after reset, `exec_occ`, `mem_occ` and `wb_occ` are 0, and an instruction whose source was in flight before reset issues with select 0.
- R2: `issue` is high exactly when `id_valid` is high and `stall` is low. `stall` is never high while `id_valid` is low. Both selects read 0 in any cycle without `issue`.
- R3: A source register whose newest in-flight producer is three or more cycles from its writeback stalls the consumer. This means the producer has not yet reached its final execution stage.
- R4: When a source register is pending and the consumer issues, the select names the value's location in that cycle. 1, 2, 3 or 4 means the producer is in the last stage of the integer, add, multiply or divide unit. 5 means it is in the memory stage and 6 means it is in writeback. 0 means the register file, which is also used when nothing is pending.
- R5: Unit class codes are 0 for integer (1 stage), 1 for add (2 stages), 2 for multiply (3 stages) and 3 for divide (4 stages). An operation issued in cycle t raises `wb_occ` in cycle t+L+2.
- R6: A divide stalls while a previous divide would still occupy the divider past the next cycle. Two divides can therefore issue no less than 4 cycles apart.
- R7: An instruction whose writeback cycle equals that of any operation already in flight stalls. At most one operation is ever in the memory or writeback stage.
- R8: An instruction stalls when the newest in-flight writer of its destination would write back in the same cycle as the new instruction or later.
- R9: `exec_occ` bit 0 is the integer stage, bits 1 and 2 are adder stages 1 and 2, bits 3 to 5 are multiplier stages 1 to 3, and bit 6 is the divider being busy. `mem_occ` and `wb_occ` flag a live operation in those stages.
- R10: A stalled or invalid cycle adds nothing to any execution stage. A held instruction enters its unit exactly once, in the cycle it issues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| id_valid | input | 1 | Decode stage holds an instruction |
| id_unit | input | 2 | Unit class of the decoded instruction |
| id_dst | input | 5 | Destination register |
| id_src1 | input | 5 | First source register |
| id_src2 | input | 5 | Second source register |
| stall | output | 1 | Hold decode, bubble into execution |
| issue | output | 1 | Instruction enters its unit this cycle |
| fwd_sel1 | output | 3 | Operand source for the first source |
| fwd_sel2 | output | 3 | Operand source for the second source |
| exec_occ | output | 7 | Occupancy of each execution stage |
| mem_occ | output | 1 | Memory stage holds an operation |
| wb_occ | output | 1 | Writeback stage holds an operation |

## Verification
Some properties are checked on every cycle. The stage tracker and the writeback reservation vector must agree on memory and writeback occupancy, and at most one unit may finish per cycle. A divide is never started while the divider is still busy, and an issuing consumer never depends on a producer that is not yet in its final stage. An issuing writer never lands at or before an older writer of the same register. The stall counts themselves can only be shown by the bench scenarios: the add/sub/div, div/add/mul and div/div/add sequences, and the forced port conflicts and ordering stalls. The exact forwarding select chosen at each distance likewise comes only from the bench, which compares every cycle of a long random stream against a latency model.

// File: rtl/fpil_pkg.sv
package fpil_pkg;

    typedef enum logic [1:0] {
        U_INT = 2'd0,
        U_ADD = 2'd1,
        U_MUL = 2'd2,
        U_DIV = 2'd3
    } unit_e;

    typedef enum logic [2:0] {
        SRC_RF  = 3'd0,
        SRC_INT = 3'd1,
        SRC_ADD = 3'd2,
        SRC_MUL = 3'd3,
        SRC_DIV = 3'd4,
        SRC_MEM = 3'd5,
        SRC_WB  = 3'd6
    } src_e;

    typedef enum logic {
        DV_IDLE = 1'b0,
        DV_RUN  = 1'b1
    } dv_state_e;

endpackage

// File: rtl/fpil_pipe.sv
module fpil_pipe #(
    parameter int DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enter,
    output logic [DEPTH-1:0] occ,
    output logic             last
);

    logic [DEPTH-1:0] q;

    generate
        if (DEPTH == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) q <= '0;
                else     q <= enter;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) q <= '0;
                else     q <= {q[DEPTH-2:0], enter};
            end
        end
    endgenerate

    assign occ  = q;
    assign last = q[DEPTH-1];

endmodule

// File: rtl/fpil_pending.sv
module fpil_pending
    import fpil_pkg::*;
#(
    parameter int NREG = 32,
    parameter int CW   = 3
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    issue,
    input  logic [1:0]              iss_unit,
    input  logic [$clog2(NREG)-1:0] iss_dst,
    input  logic [$clog2(NREG)-1:0] iss_src1,
    input  logic [$clog2(NREG)-1:0] iss_src2,
    input  logic [CW-1:0]           set_dist,
    input  logic [CW-1:0]           new_dist,
    output logic                    raw1,
    output logic                    raw2,
    output logic [2:0]              sel1,
    output logic [2:0]              sel2,
    output logic                    waw
);

    localparam int REGW = $clog2(NREG);

    logic          pv [NREG];
    logic [1:0]    pu [NREG];
    logic [CW-1:0] pr [NREG];

    always_ff @(posedge clk) begin
        for (int i = 0; i < NREG; i++) begin
            if (rst) begin
                pv[i] <= 1'b0;
                pu[i] <= '0;
                pr[i] <= '0;
            end else if (issue && iss_dst == REGW'(i)) begin
                pv[i] <= 1'b1;
                pu[i] <= iss_unit;
                pr[i] <= set_dist;
            end else if (pv[i]) begin
                if (pr[i] == '0) pv[i] <= 1'b0;
                else             pr[i] <= pr[i] - 1'b1;
            end
        end
    end

    function automatic logic [3:0] locate(input logic v, input logic [1:0] u,
                                          input logic [CW-1:0] r);
        logic       h;
        logic [2:0] s;
        h = 1'b0;
        s = SRC_RF;
        if (v) begin
            if (r > CW'(2)) begin
                h = 1'b1;
            end else if (r == CW'(2)) begin
                unique case (unit_e'(u))
                    U_INT: s = SRC_INT;
                    U_ADD: s = SRC_ADD;
                    U_MUL: s = SRC_MUL;
                    U_DIV: s = SRC_DIV;
                endcase
            end else if (r == CW'(1)) begin
                s = SRC_MEM;
            end else begin
                s = SRC_WB;
            end
        end
        return {h, s};
    endfunction

    assign {raw1, sel1} = locate(pv[iss_src1], pu[iss_src1], pr[iss_src1]);
    assign {raw2, sel2} = locate(pv[iss_src2], pu[iss_src2], pr[iss_src2]);
    assign waw          = pv[iss_dst] && (pr[iss_dst] >= new_dist);

    // R3: an issuing consumer's producer is at most in its final stage
    assert_raw_ready_R3: assert property (@(posedge clk) disable iff (rst)
        (issue && pv[iss_src1]) |-> (pr[iss_src1] <= CW'(2)));

    assert_raw_ready2_R3: assert property (@(posedge clk) disable iff (rst)
        (issue && pv[iss_src2]) |-> (pr[iss_src2] <= CW'(2)));

    // R8: an issuing writer lands strictly after the older writer
    assert_waw_order_R8: assert property (@(posedge clk) disable iff (rst)
        (issue && pv[iss_dst]) |-> (pr[iss_dst] < new_dist));

endmodule

// File: rtl/fpil_wbslot.sv
module fpil_wbslot #(
    parameter int WBW = 7,
    parameter int CW  = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          issue,
    input  logic [CW-1:0] set_idx,
    input  logic [CW-1:0] probe_idx,
    output logic          conflict,
    output logic          slot_mem,
    output logic          slot_wb
);

    logic [WBW-1:0] rsv;

    always_ff @(posedge clk) begin
        if (rst) rsv <= '0;
        else     rsv <= (rsv >> 1) | (issue ? (WBW'(1) << set_idx) : '0);
    end

    assign conflict = rsv[probe_idx];
    assign slot_mem = rsv[1];
    assign slot_wb  = rsv[0];

    // R7: an issue never claims a writeback cycle already taken
    assert_wb_free_R7: assert property (@(posedge clk) disable iff (rst)
        issue |-> !rsv[probe_idx]);

endmodule

// File: rtl/fpil_divctl.sv
module fpil_divctl
    import fpil_pkg::*;
#(
    parameter int DIV_LAT = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic blocked,
    output logic last,
    output logic occupied
);

    localparam int DCW = $clog2(DIV_LAT + 1);

    dv_state_e      st, st_n;
    logic [DCW-1:0] cnt, cnt_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= DV_IDLE;
            cnt <= '0;
        end else begin
            st  <= st_n;
            cnt <= cnt_n;
        end
    end

    always_comb begin
        st_n  = st;
        cnt_n = cnt;
        unique case (st)
            DV_IDLE: begin
                if (start) begin
                    st_n  = DV_RUN;
                    cnt_n = DCW'(DIV_LAT);
                end
            end
            DV_RUN: begin
                if (cnt == DCW'(1)) begin
                    if (start) begin
                        cnt_n = DCW'(DIV_LAT);
                    end else begin
                        st_n  = DV_IDLE;
                        cnt_n = '0;
                    end
                end else begin
                    cnt_n = cnt - 1'b1;
                end
            end
        endcase
    end

    always_comb begin
        blocked  = (st == DV_RUN) && (cnt > DCW'(1));
        last     = (st == DV_RUN) && (cnt == DCW'(1));
        occupied = (st == DV_RUN);
    end

    // R6: no divide is launched into a divider that is still busy
    assert_div_free_R6: assert property (@(posedge clk) disable iff (rst)
        start |-> !((st == DV_RUN) && (cnt > DCW'(1))));

    assert_div_idle_R6: assert property (@(posedge clk) disable iff (rst)
        (st == DV_IDLE) |-> (cnt == '0));

endmodule

// File: rtl/fpil_track.sv
module fpil_track
    import fpil_pkg::*;
#(
    parameter int INT_LAT = 1,
    parameter int ADD_LAT = 2,
    parameter int MUL_LAT = 3
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             issue,
    input  logic [1:0]                       unit,
    input  logic                             div_last,
    input  logic                             div_occ,
    output logic [INT_LAT+ADD_LAT+MUL_LAT:0] exec_occ,
    output logic                             mem_occ,
    output logic                             wb_occ,
    output logic [3:0]                       finishers
);

    logic [INT_LAT-1:0] int_occ;
    logic [ADD_LAT-1:0] add_occ;
    logic [MUL_LAT-1:0] mul_occ;
    logic int_last, add_last, mul_last;
    logic mem_q, wb_q;

    fpil_pipe #(.DEPTH(INT_LAT)) u_int (
        .clk(clk), .rst(rst), .enter(issue && unit == U_INT),
        .occ(int_occ), .last(int_last));

    fpil_pipe #(.DEPTH(ADD_LAT)) u_add (
        .clk(clk), .rst(rst), .enter(issue && unit == U_ADD),
        .occ(add_occ), .last(add_last));

    fpil_pipe #(.DEPTH(MUL_LAT)) u_mul (
        .clk(clk), .rst(rst), .enter(issue && unit == U_MUL),
        .occ(mul_occ), .last(mul_last));

    assign finishers = {div_last, mul_last, add_last, int_last};

    always_ff @(posedge clk) begin
        if (rst) begin
            mem_q <= 1'b0;
            wb_q  <= 1'b0;
        end else begin
            mem_q <= |finishers;
            wb_q  <= mem_q;
        end
    end

    assign exec_occ = {div_occ, mul_occ, add_occ, int_occ};
    assign mem_occ  = mem_q;
    assign wb_occ   = wb_q;

endmodule

// File: rtl/fpil_interlock.sv
module fpil_interlock
    import fpil_pkg::*;
#(
    parameter int NREG    = 32,
    parameter int INT_LAT = 1,
    parameter int ADD_LAT = 2,
    parameter int MUL_LAT = 3,
    parameter int DIV_LAT = 4
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             id_valid,
    input  logic [1:0]                       id_unit,
    input  logic [$clog2(NREG)-1:0]          id_dst,
    input  logic [$clog2(NREG)-1:0]          id_src1,
    input  logic [$clog2(NREG)-1:0]          id_src2,
    output logic                             stall,
    output logic                             issue,
    output logic [2:0]                       fwd_sel1,
    output logic [2:0]                       fwd_sel2,
    output logic [INT_LAT+ADD_LAT+MUL_LAT:0] exec_occ,
    output logic                             mem_occ,
    output logic                             wb_occ
);

    localparam int ML1    = (INT_LAT > ADD_LAT) ? INT_LAT : ADD_LAT;
    localparam int ML2    = (ML1 > MUL_LAT) ? ML1 : MUL_LAT;
    localparam int MAXLAT = (ML2 > DIV_LAT) ? ML2 : DIV_LAT;
    localparam int WBW    = MAXLAT + 3;
    localparam int CW     = $clog2(WBW);

    logic [CW-1:0] id_lat, set_dist, new_dist;
    logic          is_div;
    logic          raw1, raw2, waw, wb_clash;
    logic [2:0]    sel1, sel2;
    logic          div_blocked, div_last, div_occ;
    logic          slot_mem, slot_wb;
    logic [3:0]    finishers;

    always_comb begin
        unique case (unit_e'(id_unit))
            U_INT: id_lat = CW'(INT_LAT);
            U_ADD: id_lat = CW'(ADD_LAT);
            U_MUL: id_lat = CW'(MUL_LAT);
            U_DIV: id_lat = CW'(DIV_LAT);
        endcase
    end

    assign set_dist = id_lat + CW'(1);
    assign new_dist = id_lat + CW'(2);
    assign is_div   = (id_unit == U_DIV);

    fpil_pending #(.NREG(NREG), .CW(CW)) u_pend (
        .clk(clk), .rst(rst), .issue(issue), .iss_unit(id_unit),
        .iss_dst(id_dst), .iss_src1(id_src1), .iss_src2(id_src2),
        .set_dist(set_dist), .new_dist(new_dist),
        .raw1(raw1), .raw2(raw2), .sel1(sel1), .sel2(sel2), .waw(waw));

    fpil_wbslot #(.WBW(WBW), .CW(CW)) u_slot (
        .clk(clk), .rst(rst), .issue(issue),
        .set_idx(set_dist), .probe_idx(new_dist),
        .conflict(wb_clash), .slot_mem(slot_mem), .slot_wb(slot_wb));

    fpil_divctl #(.DIV_LAT(DIV_LAT)) u_div (
        .clk(clk), .rst(rst), .start(issue && is_div),
        .blocked(div_blocked), .last(div_last), .occupied(div_occ));

    fpil_track #(.INT_LAT(INT_LAT), .ADD_LAT(ADD_LAT), .MUL_LAT(MUL_LAT)) u_track (
        .clk(clk), .rst(rst), .issue(issue), .unit(id_unit),
        .div_last(div_last), .div_occ(div_occ),
        .exec_occ(exec_occ), .mem_occ(mem_occ), .wb_occ(wb_occ),
        .finishers(finishers));

    always_comb begin
        stall    = id_valid && (raw1 || raw2 || waw || wb_clash ||
                                (is_div && div_blocked));
        issue    = id_valid && !stall;
        fwd_sel1 = issue ? sel1 : SRC_RF;
        fwd_sel2 = issue ? sel2 : SRC_RF;
    end

    // R7: the stage tracker and the writeback reservations agree
    assert_mem_slot_R7: assert property (@(posedge clk) disable iff (rst)
        mem_occ == slot_mem);

    // R5: writeback occupancy matches the reserved cycle
    assert_wb_slot_R5: assert property (@(posedge clk) disable iff (rst)
        wb_occ == slot_wb);

    // R7: at most one unit finishes in any cycle
    assert_one_finisher_R7: assert property (@(posedge clk) disable iff (rst)
        $onehot0(finishers));

    // R1: everything is empty right after reset
    assert_reset_empty_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (exec_occ == '0 && !mem_occ && !wb_occ));

endmodule

// File: tb/sim_fpil_interlock.sv
module sim_fpil_interlock;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       id_valid = 1'b0;
    logic [1:0] id_unit = 2'd0;
    logic [4:0] id_dst = 5'd0, id_src1 = 5'd0, id_src2 = 5'd0;
    logic       stall, issue;
    logic [2:0] fwd_sel1, fwd_sel2;
    logic [6:0] exec_occ;
    logic       mem_occ, wb_occ;

    always #2 clk = ~clk;

    fpil_interlock u0 (
        .clk(clk), .rst(rst), .id_valid(id_valid), .id_unit(id_unit),
        .id_dst(id_dst), .id_src1(id_src1), .id_src2(id_src2),
        .stall(stall), .issue(issue), .fwd_sel1(fwd_sel1), .fwd_sel2(fwd_sel2),
        .exec_occ(exec_occ), .mem_occ(mem_occ), .wb_occ(wb_occ));

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;
    bit h_v [16];
    int h_u [16];
    int h_d [16];
    int t = 0;
    int obs_sel1, obs_sel2;

    function automatic int lat_of(input int u);
        case (u)
            0: return 1;
            1: return 2;
            2: return 3;
            default: return 4;
        endcase
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d (cycle %0d)", tag, act, exp, t);
        end
    endtask

    // where a source value is in the current cycle (R3, R4)
    function automatic void locate(input int r, output bit hit, output int sel);
        hit = 0;
        sel = 0;
        for (int k = 1; k <= 8; k++) begin
            int ix;
            int d;
            ix = (t - k) & 15;
            if (h_v[ix] && h_d[ix] == r) begin
                d = lat_of(h_u[ix]) + 2 - k;
                if (d >= 3)      hit = 1;
                else if (d == 2) sel = h_u[ix] + 1;
                else if (d == 1) sel = 5;
                else if (d == 0) sel = 6;
                return;
            end
        end
    endfunction

    task automatic step(input bit v, input int u, input int d, input int a,
                        input int b, output bit got);
        bit h1, h2, waw, wbc, dvb, e_st, e_is, em, ew, seen;
        int s1, s2, L, occ;
        @(negedge clk);
        id_valid = v;
        id_unit  = 2'(u);
        id_dst   = 5'(d);
        id_src1  = 5'(a);
        id_src2  = 5'(b);
        #1;
        L = lat_of(u);
        locate(a, h1, s1);
        locate(b, h2, s2);
        waw = 0; wbc = 0; dvb = 0; em = 0; ew = 0; occ = 0; seen = 0;
        for (int k = 1; k <= 8; k++) begin
            int ix;
            int lp;
            ix = (t - k) & 15;
            if (h_v[ix]) begin
                lp = lat_of(h_u[ix]);
                if (lp + 2 - k == L + 2) wbc = 1;
                if (u == 3 && h_u[ix] == 3 && k <= 3) dvb = 1;
                if (lp + 1 == k) em = 1;
                if (lp + 2 == k) ew = 1;
                case (h_u[ix])
                    0: if (k == 1) occ |= 1;
                    1: if (k <= 2) occ |= (1 << k);
                    2: if (k <= 3) occ |= (1 << (k + 2));
                    default: if (k <= 4) occ |= 64;
                endcase
                if (!seen && h_d[ix] == d) begin
                    seen = 1;
                    if (lp + 2 - k >= L + 2) waw = 1;
                end
            end
        end
        e_st = v && (h1 || h2 || waw || wbc || dvb);
        e_is = v && !e_st;
        if (!e_is) begin
            s1 = 0;
            s2 = 0;
        end
        check("R3/R6/R7/R8 stall", int'(stall), int'(e_st));
        check("R2 issue", int'(issue), int'(e_is));
        check("R4 fwd_sel1", int'(fwd_sel1), s1);
        check("R4 fwd_sel2", int'(fwd_sel2), s2);
        check("R9/R10 exec_occ", int'(exec_occ), occ);
        check("R9 mem_occ", int'(mem_occ), int'(em));
        check("R5 wb_occ", int'(wb_occ), int'(ew));
        obs_sel1 = int'(fwd_sel1);
        obs_sel2 = int'(fwd_sel2);
        got = e_is;
        @(posedge clk);
        h_v[t & 15] = e_is;
        h_u[t & 15] = u;
        h_d[t & 15] = d;
        t++;
    endtask

    task automatic push(input int u, input int d, input int a, input int b,
                        output int waits);
        bit g;
        waits = 0;
        forever begin
            step(1, u, d, a, b, g);
            if (g || waits > 20) break;
            waits++;
        end
    endtask

    task automatic idle(input int n);
        bit g;
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, g);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        id_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 16; i++) h_v[i] = 0;
        t = 0;
        #1;
        check("R1 reset exec_occ", int'(exec_occ), 0);
        check("R1 reset mem_occ", int'(mem_occ), 0);
        check("R1 reset wb_occ", int'(wb_occ), 0);
        check("R1 reset stall", int'(stall), 0);
    endtask

    initial begin
        #(4 * 120000);
        if (!done) begin
            n_bad++;
            $display("FAIL R2 watchdog: got 0 expected 1 (run completion)");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int w;
        do_reset();

        // add / sub / div
        push(1, 6, 3, 2, w);  check("R3 seq1 add waits", w, 0);
        push(1, 2, 8, 7, w);  check("R3 seq1 sub waits", w, 0);
        push(3, 8, 2, 8, w);  check("R3 seq1 div waits", w, 1);
        check("R4 seq1 div src1 from adder", obs_sel1, 2);
        check("R4 seq1 div src2 from file", obs_sel2, 0);
        idle(10);

        // div / add / mul
        push(3, 8, 3, 4, w);  check("R3 seq2 div waits", w, 0);
        push(1, 6, 3, 8, w);  check("R3 seq2 add waits", w, 3);
        check("R4 seq2 add src2 from divider", obs_sel2, 4);
        check("R4 seq2 add src1 from file", obs_sel1, 0);
        push(2, 9, 4, 6, w);  check("R3 seq2 mul waits", w, 1);
        check("R4 seq2 mul src2 from adder", obs_sel2, 2);
        idle(10);

        // div / div / add
        push(3, 8, 3, 2, w);  check("R6 seq3 div1 waits", w, 0);
        push(3, 9, 3, 8, w);  check("R6 seq3 div2 waits", w, 3);
        check("R4 seq3 div2 src2 from divider", obs_sel2, 4);
        push(1, 7, 7, 8, w);  check("R4 seq3 add waits", w, 0);
        check("R4 seq3 add src2 from mem latch", obs_sel2, 5);
        check("R4 seq3 add src1 from file", obs_sel1, 0);
        idle(10);

        // independent divides still serialise
        push(3, 1, 2, 3, w);
        push(3, 4, 2, 3, w);  check("R6 back-to-back divides", w, 3);
        idle(10);

        // writeback port collisions
        push(2, 10, 1, 2, w);
        push(1, 11, 1, 2, w); check("R7 add behind mul", w, 1);
        idle(10);
        push(1, 12, 1, 2, w);
        push(0, 13, 1, 2, w); check("R7 int behind add", w, 1);
        idle(10);

        // write ordering
        push(3, 1, 2, 3, w);
        push(0, 1, 2, 3, w);  check("R8 int writer behind div writer", w, 3);
        idle(10);

        // integer chain forwards from EX
        push(0, 1, 2, 3, w);
        push(0, 2, 1, 1, w);  check("R3 int chain waits", w, 0);
        check("R4 int chain src1", obs_sel1, 1);
        check("R4 int chain src2", obs_sel2, 1);
        idle(10);

        // mid-flight reset clears the pending divide
        push(3, 5, 1, 2, w);
        idle(1);
        do_reset();
        push(1, 6, 5, 5, w);  check("R1 post-reset waits", w, 0);
        check("R1 post-reset select", obs_sel1, 0);
        idle(10);

        // random stream
        void'($urandom(32'h5EED_0042));
        for (int n = 0; n < 2500; n++) begin
            if ($urandom % 6 == 0) idle(1 + $urandom % 3);
            push($urandom % 4, $urandom % 6, $urandom % 6, $urandom % 6, w);
        end
        idle(12);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule